// File: doc/BRIEF.md
# Programmable Trigger Sequencer

This block runs a short program of 8-bit steps held in a 16-entry queue. It has no CPU involvement once started. The steps emit single-cycle trigger pulses on a 32-bit trigger bus and interrupt-request pulses on a 16-bit bus. They can also push a 4-bit strobe word to a neighbouring peripheral. Other steps stall on a software trigger bit, a hardware trigger handled by a separate wait sub-block, or one of two timers in a separate timer bank. Two 16-bit loop counters give counted conditional jumps, so loops can be nested one level deep.

Software loads the queue, the loop limits, the broadcast mask and the pointer register. It raises enable, then sets the start bit. In single-step mode each start executes exactly one step and then stops, for debug.

Each step has an opcode in bits [7:4] and an option in bits [3:0]. The opcodes are:

| Opcode | Meaning |
|---|---|
| 0 | Control |
| 1 | Wait for a hardware trigger |
| 2 | Trigger, lower half of the bus |
| 3 | Trigger, upper half of the bus |
| 4 | Interrupt request |
| 5 | Strobe |
| 6 | Jump |
| 7 | Counted jump 0 |
| 8 | Counted jump 1 |
| 9 to 15 | No operation |

The strobe output is a valid/ready stream. While a strobe step is current, `strb_valid` is high and `strb_data` carries the option. Both hold until `strb_ready` is high at a clock edge, and the sequencer stalls meanwhile, so back-pressure simply lengthens the step.

Top module: `trig_seq`

## Requirements
- R1: While `en` is low, the trigger, interrupt and step-interrupt outputs are low, the start bit and software trigger bit are cleared, and both loop counters return to zero. Queue contents are kept. After `en` rises the sequencer stays halted until the start bit is set.
- R2: Once the start bit is set, the sequencer copies `ptr_o` into its internal pointer at the next edge and executes that step at the edge after. `ptr_we` writes are taken only while halted, and `ptr_o` follows the internal pointer after every completed step.
- R3: Opcode 2 pulses `trig[opt]`, opcode 3 pulses `trig[16+opt]`, and opcode 4 pulses `irq[opt]`. Each pulse lasts one cycle and is high in the cycle after the edge at which the step completes.
- R4: Opcode 0 with option 4'b1111 pulses every `trig` bit whose `bcast_mask` bit is set. Opcode 0 with any option not listed in R7, R8 or R11 completes with no effect.
- R5: Opcode 6 loads the option as the next pointer. Every other completed step advances the pointer by one, and step 15 wraps to step 0.
- R6: Opcode 7 (counter 0 against `lim0`) and opcode 8 (counter 1 against `lim1`) test their own counter. If the counter differs from its limit, the step jumps to the option and increments the counter. Otherwise it falls through and clears the counter. A limit of N therefore repeats the loop body N+1 times.
- R7: Opcode 0 with option 4'b1011 completes only on a 0-to-1 change of the software trigger bit `swt_o` seen while the step is current. On completion it clears `swt_o`.
- R8: Opcode 0 with option 4'b1010 completes when `swt_o` is 1 and leaves it set.
- R9: With `step_mode` high, each start executes exactly one step. The sequencer then clears the start bit, pulses `step_irq` for one cycle and halts.
- R10: Clearing the start bit, or a `wdt_expire` pulse while running, returns the sequencer to halt without executing. A watchdog pulse also clears the start bit.
- R11: Opcode 1 holds `hw_busy` high, with `hw_sel` equal to the option, until `hw_done`. Opcode 0 with option 4'b1000 or 4'b1001 holds `tmr_busy[0]` or `tmr_busy[1]` high until the matching `tmr_done` bit.
- R12: Opcode 5 raises `strb_valid` with `strb_data` equal to the option. Both stay stable until `strb_ready`, and the step completes on that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable |
| start_set | input | 1 | Sets the start bit |
| start_clr | input | 1 | Clears the start bit |
| step_mode | input | 1 | Single-step debug mode |
| start_o | output | 1 | Start bit |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 4 | Pointer register write data |
| ptr_o | output | 4 | Pointer register |
| swt_set | input | 1 | Sets the software trigger bit |
| swt_clr | input | 1 | Clears the software trigger bit |
| swt_o | output | 1 | Software trigger bit |
| q_we | input | 1 | Queue write strobe |
| q_waddr | input | 4 | Queue write address |
| q_wdata | input | 8 | Queue write data (step) |
| bcast_mask | input | 32 | Broadcast trigger mask |
| lim0 | input | 16 | Loop limit for counter 0 |
| lim1 | input | 16 | Loop limit for counter 1 |
| wdt_expire | input | 1 | Watchdog timeout pulse |
| hw_busy | output | 1 | Hardware trigger wait request |
| hw_sel | output | 4 | Selected hardware trigger input |
| hw_done | input | 1 | Hardware trigger seen |
| tmr_busy | output | 2 | Timer wait requests |
| tmr_done | input | 2 | Timer expiries |
| strb_valid | output | 1 | Strobe word valid |
| strb_data | output | 4 | Strobe word |
| strb_ready | input | 1 | Strobe word accepted |
| trig | output | 32 | Trigger pulses |
| irq | output | 16 | Interrupt request pulses |
| step_irq | output | 1 | Single-step completion pulse |

## Verification
A step starts executing at the second rising edge after the edge that captures `start_set`. Trigger, interrupt and step-interrupt pulses are high only in the cycle after that execution edge. By contrast, `hw_busy`, `tmr_busy` and `strb_valid` are combinational and show up in the same cycle the step becomes current. The bench drives and samples only on falling edges, and counts edges from each stimulus to the exact falling edge where a result is due. It checks single-cycle width on the following falling edge. Multi-step programs are judged by pulse counts per output bit over a window that is long enough for the program to reach its final spin step.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam logic [3:0] OP_CTRL  = 4'd0;
  localparam logic [3:0] OP_HWAIT = 4'd1;
  localparam logic [3:0] OP_TRGA  = 4'd2;
  localparam logic [3:0] OP_TRGB  = 4'd3;
  localparam logic [3:0] OP_IRQ   = 4'd4;
  localparam logic [3:0] OP_STRB  = 4'd5;
  localparam logic [3:0] OP_JMP   = 4'd6;
  localparam logic [3:0] OP_JMPC0 = 4'd7;

  localparam logic [3:0] CT_T0    = 4'b1000;
  localparam logic [3:0] CT_SWLVL = 4'b1010;
  localparam logic [3:0] CT_SWEDG = 4'b1011;
  localparam logic [3:0] CT_BCAST = 4'b1111;

  typedef enum logic {ST_HALT = 1'b0, ST_RUN = 1'b1} seq_st_e;
endpackage

// File: rtl/trig_seq_queue.sv
module trig_seq_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trig_seq_loop.sv
module trig_seq_loop #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hit,
  input  logic [CW-1:0] lim,
  output logic          take
);
  logic [CW-1:0] cnt;

  assign take = (cnt != lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (hit)    cnt <= take ? cnt + CW'(1) : '0;
  end
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int NTRIG = 32,
  parameter int NIRQ  = 16,
  parameter int AW    = 4,
  parameter int NLOOP = 2,
  localparam int HALF = NTRIG / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             step_mode,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             swt_set,
  input  logic             swt_clr,
  input  logic             wdt_expire,
  input  logic [7:0]       step,
  input  logic [NTRIG-1:0] bcast_mask,
  input  logic             hw_done,
  input  logic [1:0]       tmr_done,
  input  logic             strb_ready,
  input  logic [NLOOP-1:0] loop_take,
  output logic [AW-1:0]    rd_addr,
  output logic [NLOOP-1:0] loop_hit,
  output logic             start_o,
  output logic [AW-1:0]    ptr_o,
  output logic             swt_o,
  output logic             hw_busy,
  output logic [3:0]       hw_sel,
  output logic [1:0]       tmr_busy,
  output logic             strb_valid,
  output logic [3:0]       strb_data,
  output logic [NTRIG-1:0] trig,
  output logic [NIRQ-1:0]  irq,
  output logic             step_irq
);
  seq_st_e          st;
  logic [AW-1:0]    ptr, sw_ptr, ptr_nx;
  logic             start_q, swt_q, swt_d;
  logic [3:0]       opc, opt;
  logic             active, fire, done;
  logic [NTRIG-1:0] trig_nx;
  logic [NIRQ-1:0]  irq_nx;

  assign opc     = step[7:4];
  assign opt     = step[3:0];
  assign rd_addr = ptr;
  assign active  = (st == ST_RUN) && start_q;
  assign fire    = active && en && !wdt_expire && done;

  assign hw_busy    = active && (opc == OP_HWAIT);
  assign hw_sel     = hw_busy ? opt : 4'd0;
  assign strb_valid = active && (opc == OP_STRB);
  assign strb_data  = strb_valid ? opt : 4'd0;

  always_comb begin
    for (int i = 0; i < 2; i++)
      tmr_busy[i] = active && (opc == OP_CTRL) && (opt == CT_T0 + 4'(i));
    for (int i = 0; i < NLOOP; i++)
      loop_hit[i] = fire && (opc == OP_JMPC0 + 4'(i));
  end

  always_comb begin
    done = 1'b1;
    unique case (opc)
      OP_CTRL: begin
        unique case (opt)
          CT_T0:        done = tmr_done[0];
          CT_T0 + 4'd1: done = tmr_done[1];
          CT_SWLVL:     done = swt_q;
          CT_SWEDG:     done = swt_q && !swt_d;
          default:      done = 1'b1;
        endcase
      end
      OP_HWAIT: done = hw_done;
      OP_STRB:  done = strb_ready;
      default:  done = 1'b1;
    endcase
  end

  always_comb begin
    ptr_nx = ptr + AW'(1);
    if (opc == OP_JMP) ptr_nx = opt[AW-1:0];
    for (int i = 0; i < NLOOP; i++)
      if (opc == OP_JMPC0 + 4'(i) && loop_take[i]) ptr_nx = opt[AW-1:0];
  end

  always_comb begin
    trig_nx = '0;
    irq_nx  = '0;
    if (fire) begin
      if (opc == OP_TRGA) trig_nx[int'(opt)] = 1'b1;
      if (opc == OP_TRGB) trig_nx[HALF + int'(opt)] = 1'b1;
      if (opc == OP_CTRL && opt == CT_BCAST) trig_nx = bcast_mask;
      if (opc == OP_IRQ) irq_nx[int'(opt)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HALT; ptr <= '0; sw_ptr <= '0; start_q <= 1'b0;
      swt_q <= 1'b0; swt_d <= 1'b0; trig <= '0; irq <= '0; step_irq <= 1'b0;
    end else if (!en) begin
      st <= ST_HALT; ptr <= '0; start_q <= 1'b0;
      swt_q <= 1'b0; swt_d <= 1'b0; trig <= '0; irq <= '0; step_irq <= 1'b0;
    end else begin
      trig     <= trig_nx;
      irq      <= irq_nx;
      step_irq <= fire && step_mode;
      swt_d    <= swt_q;
      if (fire && opc == OP_CTRL && opt == CT_SWEDG) swt_q <= 1'b0;
      else if (swt_set)                              swt_q <= 1'b1;
      else if (swt_clr)                              swt_q <= 1'b0;
      if ((st == ST_RUN && wdt_expire) || (fire && step_mode)) start_q <= 1'b0;
      else if (start_clr)                                      start_q <= 1'b0;
      else if (start_set)                                      start_q <= 1'b1;
      unique case (st)
        ST_HALT: begin
          if (start_q) begin
            st  <= ST_RUN;
            ptr <= sw_ptr;
          end else if (ptr_we) begin
            sw_ptr <= ptr_wdata;
          end
        end
        ST_RUN: begin
          if (!start_q || wdt_expire) begin
            st <= ST_HALT;
          end else if (fire) begin
            ptr    <= ptr_nx;
            sw_ptr <= ptr_nx;
            if (step_mode) st <= ST_HALT;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  assign start_o = start_q;
  assign ptr_o   = sw_ptr;
  assign swt_o   = swt_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DEPTH = 16,
  parameter int NTRIG = 32,
  parameter int NIRQ  = 16,
  parameter int CW    = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int NLOOP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_set,
  input  logic             start_clr,
  input  logic             step_mode,
  output logic             start_o,
  input  logic             ptr_we,
  input  logic [AW-1:0]    ptr_wdata,
  output logic [AW-1:0]    ptr_o,
  input  logic             swt_set,
  input  logic             swt_clr,
  output logic             swt_o,
  input  logic             q_we,
  input  logic [AW-1:0]    q_waddr,
  input  logic [7:0]       q_wdata,
  input  logic [NTRIG-1:0] bcast_mask,
  input  logic [CW-1:0]    lim0,
  input  logic [CW-1:0]    lim1,
  input  logic             wdt_expire,
  output logic             hw_busy,
  output logic [3:0]       hw_sel,
  input  logic             hw_done,
  output logic [1:0]       tmr_busy,
  input  logic [1:0]       tmr_done,
  output logic             strb_valid,
  output logic [3:0]       strb_data,
  input  logic             strb_ready,
  output logic [NTRIG-1:0] trig,
  output logic [NIRQ-1:0]  irq,
  output logic             step_irq
);
  logic [AW-1:0]    rd_addr;
  logic [7:0]       step;
  logic [NLOOP-1:0] loop_hit, loop_take;
  logic [CW-1:0]    lims [NLOOP];

  assign lims[0] = lim0;
  assign lims[1] = lim1;

  trig_seq_queue #(.DEPTH(DEPTH), .W(8)) u_queue (
    .clk(clk), .rst_n(rst_n), .we(q_we), .waddr(q_waddr), .wdata(q_wdata),
    .raddr(rd_addr), .rdata(step)
  );

  for (genvar gi = 0; gi < NLOOP; gi++) begin : g_loop
    trig_seq_loop #(.CW(CW)) u_loop (
      .clk(clk), .rst_n(rst_n), .clr(!en), .hit(loop_hit[gi]),
      .lim(lims[gi]), .take(loop_take[gi])
    );
  end

  trig_seq_ctrl #(.NTRIG(NTRIG), .NIRQ(NIRQ), .AW(AW), .NLOOP(NLOOP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .start_clr(start_clr),
    .step_mode(step_mode), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .swt_set(swt_set), .swt_clr(swt_clr), .wdt_expire(wdt_expire), .step(step),
    .bcast_mask(bcast_mask), .hw_done(hw_done), .tmr_done(tmr_done),
    .strb_ready(strb_ready), .loop_take(loop_take), .rd_addr(rd_addr),
    .loop_hit(loop_hit), .start_o(start_o), .ptr_o(ptr_o), .swt_o(swt_o),
    .hw_busy(hw_busy), .hw_sel(hw_sel), .tmr_busy(tmr_busy),
    .strb_valid(strb_valid), .strb_data(strb_data), .trig(trig), .irq(irq),
    .step_irq(step_irq)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int NTRIG = 32,
  parameter int NIRQ  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             start_clr,
  input logic             wdt_expire,
  input logic             start_o,
  input logic             hw_busy,
  input logic [1:0]       tmr_busy,
  input logic             strb_valid,
  input logic [3:0]       strb_data,
  input logic             strb_ready,
  input logic [NTRIG-1:0] trig,
  input logic [NIRQ-1:0]  irq,
  input logic             step_irq
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (trig == '0 && irq == '0 && !start_o && !step_irq));

  p_one_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq) <= 1);

  p_step_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_irq |-> !start_o);

  p_wdt_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wdt_expire && hw_busy) |=> !start_o);

  p_wait_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hw_busy, tmr_busy, strb_valid}));

  p_strb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && strb_valid && !strb_ready && !start_clr && !wdt_expire)
      |=> (strb_valid && $stable(strb_data)));
endmodule

bind trig_seq trig_seq_chk #(.NTRIG(NTRIG), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start_clr(start_clr), .wdt_expire(wdt_expire),
  .start_o(start_o), .hw_busy(hw_busy), .tmr_busy(tmr_busy), .strb_valid(strb_valid),
  .strb_data(strb_data), .strb_ready(strb_ready), .trig(trig), .irq(irq),
  .step_irq(step_irq)
);

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, start_set = 1'b0, start_clr = 1'b0, step_mode = 1'b0;
  logic        start_o;
  logic        ptr_we = 1'b0;
  logic [3:0]  ptr_wdata = '0, ptr_o;
  logic        swt_set = 1'b0, swt_clr = 1'b0, swt_o;
  logic        q_we = 1'b0;
  logic [3:0]  q_waddr = '0;
  logic [7:0]  q_wdata = '0;
  logic [31:0] bcast_mask = 32'h8000_0101;
  logic [15:0] lim0 = '0, lim1 = '0;
  logic        wdt_expire = 1'b0;
  logic        hw_busy, hw_done = 1'b0;
  logic [3:0]  hw_sel;
  logic [1:0]  tmr_busy, tmr_done = '0;
  logic        strb_valid, strb_ready = 1'b1;
  logic [3:0]  strb_data;
  logic [31:0] trig;
  logic [15:0] irq;
  logic        step_irq;

  int nchk = 0, nfail = 0;
  int tcnt [32];
  int icnt [16];

  always #10 clk = ~clk;

  trig_seq dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .start_clr(start_clr),
    .step_mode(step_mode), .start_o(start_o), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr_o(ptr_o), .swt_set(swt_set), .swt_clr(swt_clr), .swt_o(swt_o), .q_we(q_we),
    .q_waddr(q_waddr), .q_wdata(q_wdata), .bcast_mask(bcast_mask), .lim0(lim0),
    .lim1(lim1), .wdt_expire(wdt_expire), .hw_busy(hw_busy), .hw_sel(hw_sel),
    .hw_done(hw_done), .tmr_busy(tmr_busy), .tmr_done(tmr_done),
    .strb_valid(strb_valid), .strb_data(strb_data), .strb_ready(strb_ready),
    .trig(trig), .irq(irq), .step_irq(step_irq)
  );

  // {ptr, step, expected trig, expected irq, expected next pointer}
  localparam logic [63:0] VEC [10] = '{
    {4'd0,  8'h25, 32'h0000_0020, 16'h0000, 4'd1},
    {4'd1,  8'h33, 32'h0008_0000, 16'h0000, 4'd2},
    {4'd2,  8'h47, 32'h0000_0000, 16'h0080, 4'd3},
    {4'd3,  8'h6C, 32'h0000_0000, 16'h0000, 4'd12},
    {4'd4,  8'h0F, 32'h8000_0101, 16'h0000, 4'd5},
    {4'd5,  8'h90, 32'h0000_0000, 16'h0000, 4'd6},
    {4'd15, 8'h20, 32'h0000_0001, 16'h0000, 4'd0},
    {4'd7,  8'h7A, 32'h0000_0000, 16'h0000, 4'd8},
    {4'd8,  8'h8B, 32'h0000_0000, 16'h0000, 4'd11},
    {4'd9,  8'h00, 32'h0000_0000, 16'h0000, 4'd10}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input logic [3:0] a, input logic [7:0] d);
    q_we = 1'b1; q_waddr = a; q_wdata = d; tick(); q_we = 1'b0;
  endtask

  task automatic setp(input logic [3:0] p);
    ptr_wdata = p; ptr_we = 1'b1; tick(); ptr_we = 1'b0;
  endtask

  task automatic go();
    start_set = 1'b1; tick(); start_set = 1'b0;
  endtask

  task automatic reen();
    en = 1'b0; tick(); en = 1'b1; tick();
  endtask

  task automatic clr_counts();
    for (int b = 0; b < 32; b++) tcnt[b] = 0;
    for (int b = 0; b < 16; b++) icnt[b] = 0;
  endtask

  task automatic run_count(input int n);
    for (int c = 0; c < n; c++) begin
      tick();
      for (int b = 0; b < 32; b++) tcnt[b] += int'(trig[b]);
      for (int b = 0; b < 16; b++) icnt[b] += int'(irq[b]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 trig at reset", 64'(trig), 0);
    chk("R1 irq at reset", 64'(irq), 0);
    chk("R1 start at reset", 64'(start_o), 0);
    chk("R2 ptr at reset", 64'(ptr_o), 0);
    chk("R12 strobe idle at reset", 64'(strb_valid), 0);

    en = 1'b1; step_mode = 1'b1; lim0 = 16'd0; lim1 = 16'd2;
    tick();
    // single-step vector walk: R3 R4 R5 R6 R9
    for (int v = 0; v < 10; v++) begin
      wq(VEC[v][63:60], VEC[v][59:52]);
      setp(VEC[v][63:60]);
      go();
      tick(); tick();
      chk("R3 R4 trig pulse", 64'(trig), 64'(VEC[v][51:20]));
      chk("R3 irq pulse", 64'(irq), 64'(VEC[v][19:4]));
      chk("R9 step_irq", 64'(step_irq), 1);
      chk("R9 start cleared", 64'(start_o), 0);
      chk("R5 R6 next ptr", 64'(ptr_o), 64'(VEC[v][3:0]));
      tick();
      chk("R3 pulse width", 64'(trig), 0);
      chk("R9 single step only", 64'(step_irq), 0);
    end

    // R6 nested loops; R1 re-enable clears counter 1 left at 1 above
    step_mode = 1'b0; reen();
    lim0 = 16'd1; lim1 = 16'd2;
    wq(4'd0, 8'h21); wq(4'd1, 8'h70); wq(4'd2, 8'h30);
    wq(4'd3, 8'h80); wq(4'd4, 8'h43); wq(4'd5, 8'h65);
    setp(4'd0); clr_counts(); go(); run_count(40);
    chk("R6 inner body count", 64'(tcnt[1]), 6);
    chk("R6 outer body count", 64'(tcnt[16]), 3);
    chk("R6 exit irq", 64'(icnt[3]), 1);
    chk("R5 spin ptr", 64'(ptr_o), 5);

    // R10 start clear stops a running loop
    reen();
    wq(4'd0, 8'h27); wq(4'd1, 8'h60);
    setp(4'd0); clr_counts(); go(); run_count(8);
    chk("R2 loop runs", 64'(tcnt[7] >= 3), 1);
    start_clr = 1'b1; tick(); start_clr = 1'b0;
    clr_counts(); run_count(8);
    chk("R10 halted after start clear", 64'(tcnt[7]), 0);
    chk("R10 start bit low", 64'(start_o), 0);

    // R1 enable drop while running, then stays halted
    go(); run_count(4);
    en = 1'b0; tick();
    chk("R1 trig off", 64'(trig), 0);
    chk("R1 start off", 64'(start_o), 0);
    en = 1'b1; clr_counts(); run_count(8);
    chk("R1 halted after enable", 64'(tcnt[7]), 0);

    // R7 edge software wait
    reen();
    wq(4'd0, 8'h0B); wq(4'd1, 8'h22); wq(4'd2, 8'h62);
    swt_set = 1'b1; tick(); swt_set = 1'b0;
    setp(4'd0); clr_counts(); go(); run_count(10);
    chk("R7 no completion on held bit", 64'(tcnt[2]), 0);
    swt_clr = 1'b1; tick(); swt_clr = 1'b0;
    run_count(3);
    swt_set = 1'b1; tick(); swt_set = 1'b0;
    run_count(5);
    chk("R7 completes on rising bit", 64'(tcnt[2]), 1);
    chk("R7 bit cleared", 64'(swt_o), 0);

    // R8 level software wait
    reen();
    wq(4'd0, 8'h0A); wq(4'd1, 8'h23); wq(4'd2, 8'h62);
    setp(4'd0); clr_counts(); go(); run_count(8);
    chk("R8 waits while low", 64'(tcnt[3]), 0);
    swt_set = 1'b1; tick(); swt_set = 1'b0;
    run_count(5);
    chk("R8 completes on level", 64'(tcnt[3]), 1);
    chk("R8 bit kept", 64'(swt_o), 1);

    // R11 hardware wait then timer 0 wait
    reen();
    wq(4'd0, 8'h13); wq(4'd1, 8'h08); wq(4'd2, 8'h24); wq(4'd3, 8'h63);
    setp(4'd0); clr_counts(); go(); run_count(4);
    chk("R11 hw busy", 64'(hw_busy), 1);
    chk("R11 hw select", 64'(hw_sel), 3);
    hw_done = 1'b1; tick(); hw_done = 1'b0;
    chk("R11 timer busy", 64'(tmr_busy), 1);
    chk("R11 hw released", 64'(hw_busy), 0);
    run_count(4);
    chk("R11 timer holds step", 64'(tcnt[4]), 0);
    tmr_done = 2'b01; tick(); tmr_done = 2'b00;
    run_count(3);
    chk("R11 after timer", 64'(tcnt[4]), 1);

    // R10 watchdog during hardware wait
    reen();
    wq(4'd0, 8'h15); wq(4'd1, 8'h60);
    setp(4'd0); go(); run_count(4);
    chk("R11 hw busy before timeout", 64'(hw_busy), 1);
    wdt_expire = 1'b1; tick(); wdt_expire = 1'b0;
    chk("R10 watchdog clears start", 64'(start_o), 0);
    chk("R10 watchdog halts", 64'(hw_busy), 0);

    // R12 strobe back-pressure
    reen();
    strb_ready = 1'b0;
    wq(4'd0, 8'h5A); wq(4'd1, 8'h26); wq(4'd2, 8'h62);
    setp(4'd0); clr_counts(); go(); run_count(5);
    chk("R12 valid held", 64'(strb_valid), 1);
    chk("R12 data held", 64'(strb_data), 64'hA);
    chk("R12 stalled", 64'(tcnt[6]), 0);
    strb_ready = 1'b1;
    run_count(4);
    chk("R12 completes on handshake", 64'(tcnt[6]), 1);
    chk("R12 valid dropped", 64'(strb_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule